// File: doc/BRIEF.md
# Multi-output clock divider controller

This block is the digital half of a clock controller that sits behind an analog PLL. It receives a reference clock and the raw PLL output. A source mux picks between the reference and a post-divided copy of the PLL clock. The selected source then feeds seven domain dividers, and each domain has its own ratio and its own gate. An auxiliary output repeats the reference clock and is never divided or switched.

Software programs the block through a small register port in the reference clock domain. The port holds the multiplier field that is passed to the analog PLL, the power-down control, the post-divider ratio, the seven domain ratios, the gate mask and the PLL enable. After reset the block runs from the reference. Software sets the multiplier and the ratios, waits for lock, clears power-down, and then sets the PLL enable.

A ratio write stays pending until software sets GO. On GO, all seven dividers load their new ratios and restart together on one source edge. Every domain output is built by passing whole high phases of the source clock. As a result, no ratio change, gate change or source switch can produce a phase shorter than a phase of the source.

Top module: `clkdiv_ctrl`

## Requirements
- R1: After reset, the CTRL register (address 0) reads 4'b0010: bit0 PLL enable = 0, bit1 power-down = 1, bit2 busy = 0, bit3 source-is-PLL = 0. The gate mask (address 3) reads 7'h7f, every ratio field reads 0, `pll_pwrdn` is 1, and the domains run at ratio 1 from the reference.
- R2: `aux_clk` follows `ref_clk` at all times, whatever the source selection or the divider settings.
- R3: Each domain ratio field is 5 bits wide, at address 8+i for domain i, and gives a ratio of field+1 (1 to 32). The period of `dom_clk[i]` equals that ratio times the period of the selected source.
- R4: A ratio write does not change the running ratio and reads back as the pending value. Writing 1 to CTRL bit2 (GO) applies all pending ratios. Bit2 reads 1 until the realignment has completed and then returns to 0 by itself.
- R5: After GO, all domains restart on a common source edge. Domains with equal ratios then rise at the same instants.
- R6: Clearing bit i of the gate mask holds `dom_clk[i]` low and leaves the other domains running. Setting the bit again resumes the domain in phase with the others.
- R7: A write that sets CTRL bit0 is ignored while `pll_locked` is low or power-down is set: bit0 reads back 0 and the source stays on the reference.
- R8: With CTRL bit0 at 1, the domains run from the post-divided PLL clock and CTRL bit3 reads 1. Clearing bit0 returns them to the reference and bit3 to 0.
- R9: The post-divider field (address 2, 5 bits, ratio field+1) takes effect only while the PLL path is not selected. A write made while the PLL path is selected has no effect until the source has been switched away and back.
- R10: No domain output shows a high or low phase shorter than the shortest half-period of the two clocks the mux can select, through ratio changes, gating and source switches.
- R11: `pll_mult` drives the value of the multiplier register (address 1, 5 bits), and `pll_pwrdn` drives CTRL bit1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; also clocks the register port |
| pll_clk | input | 1 | Raw clock from the analog PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | Lock indication from the PLL |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational from addr) |
| pll_mult | output | 5 | Multiplier field to the PLL |
| pll_pwrdn | output | 1 | PLL power-down control |
| aux_clk | output | 1 | Reference clock repeated |
| dom_clk | output | 7 | Domain clocks |

## Verification
The bench sweeps ratios 1 to 8 across all seven domains in rotating patterns and also hits the 32 limit. A divider with an off-by-one in its terminal count would show every measured period one source cycle wrong. It sets equal ratios on domains left misaligned by earlier sweeps, so dividers that do not restart together on GO show different rise instants. It switches the source both ways and writes the post-divider while the PLL path is selected, which catches a mux that overlaps its sources and a post-divider that changes ratio under a live clock. An edge monitor measures every phase on every output throughout the run, so any runt from a mux, gate or ratio change shows up as a too-short phase.

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl #(
  parameter int NDOM = 7,
  parameter int RW   = 5,
  parameter int MW   = 5,
  parameter int AW   = 4
) (
  input  logic            ref_clk,
  input  logic            pll_clk,
  input  logic            rst_n,
  input  logic            pll_locked,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic [MW-1:0]   pll_mult,
  output logic            pll_pwrdn,
  output logic            aux_clk,
  output logic [NDOM-1:0] dom_clk
);
  localparam int RAT_BASE = 8;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_MULT = AW'(1);
  localparam logic [AW-1:0] A_PDIV = AW'(2);
  localparam logic [AW-1:0] A_GATE = AW'(3);

  logic pllen, pwrdn, go, src_pll, src_s1, ack_r1, ack_r2;
  logic [MW-1:0] mult_q;
  logic [RW-1:0] pd_p, pd_act, pcnt;
  logic [NDOM-1:0] gate_q, gm1, gm2;
  logic [RW-1:0] rat_p [NDOM];
  logic en_ref, en_pll, epr1, epr2, sp1, sp2, erp1, erp2, pen;
  logic post_clk, mclk, go_m1, go_m2, go_m3, load;

  wire unused_wdata = &{1'b0, wdata};

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      pllen <= 1'b0; pwrdn <= 1'b1; go <= 1'b0;
      src_s1 <= 1'b0; src_pll <= 1'b0; ack_r1 <= 1'b0; ack_r2 <= 1'b0;
      mult_q <= '0; pd_p <= '0; gate_q <= '1;
      for (int i = 0; i < NDOM; i++) rat_p[i] <= '0;
    end else begin
      ack_r1 <= go_m2; ack_r2 <= ack_r1;
      src_s1 <= en_pll; src_pll <= src_s1;
      if (go && ack_r2) go <= 1'b0;
      if (wr_en) begin
        if (addr == A_CTRL) begin
          pwrdn <= wdata[1];
          pllen <= wdata[0] && (pllen || (pll_locked && !pwrdn));
          if (wdata[2] && !go && !ack_r2) go <= 1'b1;
        end
        if (addr == A_MULT) mult_q <= wdata[MW-1:0];
        if (addr == A_PDIV) pd_p <= wdata[RW-1:0];
        if (addr == A_GATE) gate_q <= wdata[NDOM-1:0];
        for (int i = 0; i < NDOM; i++)
          if (addr == AW'(RAT_BASE + i)) rat_p[i] <= wdata[RW-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL) rdata[3:0] = {src_pll, go | ack_r2, pwrdn, pllen};
    if (addr == A_MULT) rdata[MW-1:0] = mult_q;
    if (addr == A_PDIV) rdata[RW-1:0] = pd_p;
    if (addr == A_GATE) rdata[NDOM-1:0] = gate_q;
    for (int i = 0; i < NDOM; i++)
      if (addr == AW'(RAT_BASE + i)) rdata[RW-1:0] = rat_p[i];
  end

  assign pll_mult  = mult_q;
  assign pll_pwrdn = pwrdn;
  assign aux_clk   = ref_clk;

  // R7
  pllen_gate_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(pllen) |-> $past(pll_locked && !pwrdn));
  // R4
  go_clear_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(go) |-> $past(ack_r2));

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ref <= 1'b1; epr1 <= 1'b0; epr2 <= 1'b0;
    end else begin
      epr1 <= en_pll; epr2 <= epr1;
      en_ref <= !pllen && !epr2;
    end
  end

  always_ff @(negedge pll_clk or negedge rst_n) begin
    if (!rst_n) begin
      en_pll <= 1'b0; sp1 <= 1'b0; sp2 <= 1'b0; erp1 <= 1'b1; erp2 <= 1'b1; pen <= 1'b0;
    end else begin
      sp1 <= pllen; sp2 <= sp1;
      erp1 <= en_ref; erp2 <= erp1;
      en_pll <= sp2 && !erp2;
      pen <= (pcnt == '0);
    end
  end

  always_ff @(posedge pll_clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_act <= '0; pcnt <= '0;
    end else begin
      if (!en_pll) pd_act <= pd_p;
      pcnt <= (pcnt >= pd_act) ? '0 : pcnt + 1'b1;
    end
  end

  // R9
  pdiv_hold_chk: assert property (@(posedge pll_clk) disable iff (!rst_n)
    !$stable(pd_act) |-> $past(!en_pll));
  // R8
  mux_excl_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(en_ref && en_pll));

  assign post_clk = pll_clk & pen;
  assign mclk = (ref_clk & en_ref) | (post_clk & en_pll);
  assign load = go_m2 && !go_m3;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      go_m1 <= 1'b0; go_m2 <= 1'b0; go_m3 <= 1'b0; gm1 <= '1; gm2 <= '1;
    end else begin
      go_m1 <= go; go_m2 <= go_m1; go_m3 <= go_m2;
      gm1 <= gate_q; gm2 <= gm1;
    end
  end

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    logic [RW-1:0] cnt, rat_a;
    logic en_l;
    always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0; rat_a <= '0;
      end else if (load) begin
        cnt <= '0; rat_a <= rat_p[g];
      end else begin
        cnt <= (cnt >= rat_a) ? '0 : cnt + 1'b1;
      end
    end
    always_ff @(negedge mclk or negedge rst_n) begin
      if (!rst_n) en_l <= 1'b0;
      else        en_l <= (cnt == '0) && gm2[g];
    end
    assign dom_clk[g] = mclk & en_l;
    // R3
    cnt_range_chk: assert property (@(posedge mclk) disable iff (!rst_n)
      cnt <= rat_a);
  end
endmodule

// File: tb/clkdiv_ctrl_bench.sv
`timescale 1ns/1ps
module clkdiv_ctrl_bench;
  logic ref_clk = 0, pll_clk = 0, rst_n = 0, pll_locked = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata, v;
  logic [4:0] pll_mult;
  logic pll_pwrdn, aux_clk;
  logic [6:0] dom_clk, dprev;
  int total = 0, bad = 0, glitches = 0;
  real last_r[7], prev_r[7], last_e[7];
  int rises[7];
  bit mon_on = 0, sh_en = 0, sh_pd = 1;

  always #2.5 ref_clk = ~ref_clk;
  always #0.8 pll_clk = ~pll_clk;

  clkdiv_ctrl u_clkdiv_ctrl (.ref_clk(ref_clk), .pll_clk(pll_clk), .rst_n(rst_n),
    .pll_locked(pll_locked), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pll_mult(pll_mult), .pll_pwrdn(pll_pwrdn), .aux_clk(aux_clk), .dom_clk(dom_clk));

  initial for (int i = 0; i < 7; i++) begin last_r[i] = 0; prev_r[i] = 0; last_e[i] = 0; rises[i] = 0; end

  always @(dom_clk) begin
    for (int i = 0; i < 7; i++) if (dom_clk[i] !== dprev[i]) begin
      if (mon_on && ($realtime - last_e[i] < 0.75)) begin
        glitches++;
        $display("FAIL R10 dom%0d short phase: actual=%0.3f expected>=0.750", i, $realtime - last_e[i]);
      end
      last_e[i] = $realtime;
      if (dom_clk[i] === 1'b1) begin prev_r[i] = last_r[i]; last_r[i] = $realtime; rises[i]++; end
    end
    dprev = dom_clk;
  end

  function automatic real absr(input real x); return (x < 0) ? -x : x; endfunction

  task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp); end
  endtask

  task automatic wait_ref(input int n); repeat (n) @(negedge ref_clk); endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge ref_clk); wr_en = 1; addr = a; wdata = d;
    @(negedge ref_clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge ref_clk); addr = a; #0.3; d = rdata;
  endtask

  task automatic ctrl(input bit en, input bit pd);
    sh_en = en; sh_pd = pd; wr(0, {30'b0, pd, en});
  endtask

  task automatic go_wait();
    logic [31:0] r;
    wr(0, {29'b0, 1'b1, sh_pd, sh_en});
    r = 32'h4;
    for (int n = 0; n < 200 && r[2]; n++) rd(0, r);
    chk(r[2] == 0, "R4", "GO self-clear", r[2], 0);
    wait_ref(110);
  endtask

  task automatic per(input int i, input real exp, input string req);
    real p;
    p = last_r[i] - prev_r[i];
    chk(absr(p - exp) < 0.01, req, $sformatf("dom%0d period", i), p, exp);
  endtask

  initial begin
    wait_ref(5); rst_n = 1; mon_on = 1;
    rd(0, v); chk(v[3:0] == 4'b0010, "R1", "ctrl reset", v[3:0], 2);
    rd(3, v); chk(v[6:0] == 7'h7f, "R1", "gate reset", v[6:0], 127);
    rd(12, v); chk(v[4:0] == 0, "R1", "ratio reset", v[4:0], 0);
    chk(pll_pwrdn == 1, "R1", "pwrdn port", pll_pwrdn, 1);
    wait_ref(10); per(0, 5.0, "R1"); per(6, 5.0, "R1");

    for (int n = 0; n < 4; n++) begin
      @(posedge ref_clk); #0.5; chk(aux_clk == 1, "R2", "aux high", aux_clk, 1);
      @(negedge ref_clk); #0.5; chk(aux_clk == 0, "R2", "aux low", aux_clk, 0);
    end

    wr(1, 32'h13); chk(pll_mult == 5'h13, "R11", "mult port", pll_mult, 19);

    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 7; i++) wr(4'(8 + i), (i + k) % 8);
      go_wait();
      for (int i = 0; i < 7; i++) per(i, 5.0 * ((i + k) % 8 + 1), "R3");
    end
    wr(14, 31); wr(8, 0); go_wait();
    per(6, 160.0, "R3"); per(0, 5.0, "R3");

    // dom2 currently field 5 (ratio 6)
    wr(10, 1); wait_ref(110);
    per(2, 30.0, "R4");
    rd(10, v); chk(v[4:0] == 1, "R4", "pending readback", v[4:0], 1);
    go_wait(); per(2, 10.0, "R4");

    for (int i = 0; i < 7; i++) wr(4'(8 + i), 3);
    go_wait();
    for (int i = 0; i < 7; i++)
      chk(absr(last_r[i] - last_r[0]) < 0.01, "R5", $sformatf("dom%0d align", i), last_r[i], last_r[0]);
    per(4, 20.0, "R5");

    begin
      int r3, r1;
      wr(3, 32'h77); wait_ref(20); r3 = rises[3]; r1 = rises[1];
      wait_ref(40);
      chk(rises[3] == r3, "R6", "gated no edges", rises[3], r3);
      chk(dom_clk[3] == 0, "R6", "gated low", dom_clk[3], 0);
      chk(rises[1] > r1, "R6", "neighbour runs", rises[1], r1 + 1);
      wr(3, 32'h7f); wait_ref(20);
      chk(rises[3] > r3, "R6", "resumed", rises[3], r3 + 1);
      chk(absr(last_r[3] - last_r[0]) < 0.01, "R6", "resume aligned", last_r[3], last_r[0]);
    end

    ctrl(0, 0); chk(pll_pwrdn == 0, "R11", "pwrdn cleared", pll_pwrdn, 0);
    wr(0, 1); rd(0, v);
    chk(v[0] == 0, "R7", "pllen unlocked", v[0], 0);
    chk(v[3] == 0, "R7", "src unlocked", v[3], 0);
    @(negedge ref_clk); pll_locked = 1;
    ctrl(0, 1); wr(0, 3); rd(0, v);
    chk(v[0] == 0, "R7", "pllen powered down", v[0], 0);
    wait_ref(20); per(0, 20.0, "R7");

    wr(2, 1); wait_ref(10);
    ctrl(0, 0); ctrl(1, 0);
    rd(0, v); chk(v[0] == 1, "R8", "pllen set", v[0], 1);
    wait_ref(40); rd(0, v); chk(v[3] == 1, "R8", "src pll", v[3], 1);
    wait_ref(110);
    for (int i = 0; i < 7; i++) per(i, 12.8, "R8");

    wr(2, 2); wait_ref(110); per(0, 12.8, "R9");
    ctrl(0, 0); wait_ref(40); rd(0, v); chk(v[3] == 0, "R8", "src ref", v[3], 0);
    wait_ref(110); per(0, 20.0, "R8");
    ctrl(1, 0); wait_ref(40); rd(0, v); chk(v[3] == 1, "R9", "src pll again", v[3], 1);
    wait_ref(110); per(0, 19.2, "R9");

    for (int i = 0; i < 7; i++) wr(4'(8 + i), i);
    go_wait();
    for (int i = 0; i < 7; i++) per(i, 4.8 * (i + 1), "R3");
    wr(3, 32'h2a); wait_ref(30); wr(3, 32'h7f); wait_ref(30);
    ctrl(0, 0); wait_ref(60);

    chk(glitches == 0, "R10", "short phases", glitches, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #150000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule